// File: doc/BRIEF.md
# Strobed Port Pair Controller

This block gives a CPU two 8-bit handshaked ports, A and B. Each port works on its own as either a latched input or a latched output. The handshake and interrupt lines sit on fixed bits of an 8-bit third port, C. A CPU write to the control address sets a new configuration. That configuration picks the direction of each port, and with it the meaning of every port C pin and the direction of the two port C bits left spare.

For an output port, a CPU write latches the data and drives the full flag active. A low acknowledge from the peripheral frees the buffer. The rising edge of the acknowledge raises an interrupt if that port's enable is set. For an input port, a low strobe captures the pad data and sets the buffer-full flag. The strobe's rising edge raises an interrupt if enabled, and a CPU read of the port drops both the flag and the interrupt. Control words with bit 7 clear set or clear one port C bit at a time. This is how the interrupt enables and the spare output bits are written.

The pad bus is split into separate in, out and output-enable signals. CPU addresses are 0 = port A, 1 = port B, 2 = port C, 3 = control.

Top module: `strobed_port_pair`

## Requirements
- R1: After reset, both ports are inputs and the spare bits PC6/PC7 are inputs. All latches, flags, interrupts and enables are zero. pa_oe = pb_oe = 0, pc_oe = 8'h2B and pc_out = 8'h00.
- R2: A control write with bit 7 = 1 is applied only if bits 6:5 = 01 and bit 2 = 1. Bit 4 then sets port A direction, bit 1 sets port B direction and bit 3 sets the spare-bit direction, each 1 = input. Any other word with bit 7 = 1 changes nothing.
- R3: An applied configuration word zeroes both port latches, both full flags, pending interrupts, both interrupt enables and the spare output latches.
- R4: Port A pin map. PC3 is always A's interrupt (output). As input: PC4 = strobe (in), PC5 = full (out, high = full), PC6/PC7 spare. As output: PC7 = full (out, low = full), PC6 = acknowledge (in), PC4/PC5 spare. Spare bits are outputs when the spare direction is 0. An undriven or input pc_out bit reads 0.
- R5: Port B pin map. PC0 is B's interrupt (output) and PC2 is its strobe or acknowledge (input). PC1 is its full flag: high = full as input, low = full as output. pa_oe/pb_oe are 1 exactly for an output port. pa_out/pb_out show the port latch when the port is an output and 0 otherwise.
- R6: For an output port, a CPU write latches the data and makes the full flag active at the next edge. An edge that samples the acknowledge low clears the flag. A write in the same cycle as a low acknowledge leaves the flag set.
- R7: For an output port, an acknowledge that is low at one edge and high at the next sets a pending interrupt if the enable is set. A CPU write to that port clears the pending interrupt, and the write wins over a same-cycle rising acknowledge.
- R8: For an input port, each edge that samples the strobe low latches the pad data and sets the full flag. A CPU read of the port clears the flag unless the strobe is low in that cycle. CPU writes to an input port and reads of an output port have no effect.
- R9: For an input port, a strobe that is low at one edge and high at the next sets a pending interrupt if enabled, even in the same cycle as a read. Otherwise a read clears it.
- R10: A control word with bit 7 = 0 selects port C bit (bits 3:1) and a value (bit 0). The bit that drives an enable is PC4 for A as input, PC6 for A as output and PC2 for B; that bit writes the enable. Selecting a spare bit writes that spare latch. Other bits are ignored. An interrupt output is the pending interrupt gated by its enable.
- R11: rdata is combinational on addr. 0 and 1 give the port latch. 2 gives port C, where each bit is pc_out where pc_oe = 1 and pc_in otherwise. 3 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe for this cycle |
| rd_en | input | 1 | CPU read strobe for this cycle |
| addr | input | 2 | CPU register select |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | CPU read data |
| pa_in | input | 8 | Port A pad input |
| pa_out | output | 8 | Port A pad output |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pad input |
| pb_out | output | 8 | Port B pad output |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 8 | Port C pad input |
| pc_out | output | 8 | Port C pad output |
| pc_oe | output | 8 | Port C per-bit output enable |

## Verification
The bench drives a write to an output port in the same cycle as a low acknowledge. A design that lets the acknowledge win would show an empty buffer while fresh data waits. It also drives a read in the same cycle as a low strobe. A design that lets the read win would lose the new byte's full flag. It switches port A between directions and sets enables by bit set/reset. A design that decodes the enable bit or the spare bits without regard to direction would either write the wrong enable or disturb a handshake pin. Malformed mode words and configuration changes in mid-handshake test that a rejected word leaves everything alone and that an applied one clears all state.

// File: rtl/spp_pkg.sv
package spp_pkg;
  localparam int BUS_W   = 8;
  localparam int PC_W    = 8;
  localparam int SPARE_N = 2;
  localparam int PORT_N  = 2;

  localparam logic [1:0] ADDR_PC  = 2'd2;
  localparam logic [1:0] ADDR_CTL = 2'd3;
  localparam logic [2:0] INTE_B_BIT = 3'd2;

  typedef struct packed {
    logic a_in;
    logic b_in;
    logic spare_in;
  } spp_cfg_t;

  localparam spp_cfg_t CFG_RESET = '{a_in: 1'b1, b_in: 1'b1, spare_in: 1'b1};

  function automatic logic mode_word_ok(input logic [BUS_W-1:0] w);
    return w[7] & (w[6:5] == 2'b01) & w[2];
  endfunction

  function automatic logic [2:0] inte_a_bit(input logic a_in);
    return a_in ? 3'd4 : 3'd6;
  endfunction

  function automatic logic spare_hit(input logic a_in, input logic [2:0] b);
    return a_in ? (b[2:1] == 2'b11) : (b[2:1] == 2'b10);
  endfunction

  function automatic logic [PC_W-1:0] pc_dir_mask(input spp_cfg_t c);
    logic [PC_W-1:0] m;
    m = 8'b0000_1011;
    if (c.a_in) begin
      m[5] = 1'b1;
      m[6] = ~c.spare_in;
      m[7] = ~c.spare_in;
    end else begin
      m[7] = 1'b1;
      m[4] = ~c.spare_in;
      m[5] = ~c.spare_in;
    end
    return m;
  endfunction
endpackage

// File: rtl/spp_ctrl.sv
module spp_ctrl
  import spp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr,
  input  logic [BUS_W-1:0]   wdata,
  output spp_cfg_t           cfg,
  output logic               mode_clr,
  output logic               inte_a,
  output logic               inte_b,
  output logic [SPARE_N-1:0] spare
);
  logic       mode_hit, bsr_hit, bsr_val;
  logic [2:0] bsr_sel;
  logic       sel_inte_a, sel_inte_b, sel_spare;

  assign mode_hit   = ctl_wr & mode_word_ok(wdata);
  assign bsr_hit    = ctl_wr & ~wdata[7];
  assign bsr_sel    = wdata[3:1];
  assign bsr_val    = wdata[0];
  assign sel_inte_a = bsr_hit & (bsr_sel == inte_a_bit(cfg.a_in));
  assign sel_inte_b = bsr_hit & (bsr_sel == INTE_B_BIT);
  assign sel_spare  = bsr_hit & spare_hit(cfg.a_in, bsr_sel);
  assign mode_clr   = mode_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= CFG_RESET;
      inte_a <= 1'b0;
      inte_b <= 1'b0;
      spare  <= '0;
    end else if (mode_hit) begin
      cfg    <= '{a_in: wdata[4], b_in: wdata[1], spare_in: wdata[3]};
      inte_a <= 1'b0;
      inte_b <= 1'b0;
      spare  <= '0;
    end else begin
      if (sel_inte_a) inte_a <= bsr_val;
      if (sel_inte_b) inte_b <= bsr_val;
      if (sel_spare)  spare[bsr_sel[0]] <= bsr_val;
    end
  end

  assert_mode_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_hit |=> (cfg.a_in == $past(wdata[4])) && (cfg.b_in == $past(wdata[1]))
                 && (cfg.spare_in == $past(wdata[3])));

  assert_bad_mode_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wdata[7] && !mode_hit) |=> $stable({cfg, inte_a, inte_b, spare}));

  assert_mode_clears_enables_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_hit |=> (!inte_a && !inte_b && spare == '0));
endmodule

// File: rtl/spp_chan.sv
module spp_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         dir_in,
  input  logic         inte,
  input  logic         cpu_wr,
  input  logic         cpu_rd,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pad_in,
  input  logic         hs_pin,
  output logic [W-1:0] lat_q,
  output logic         full_q,
  output logic         intr
);
  logic hs_prev, pend_q;
  logic hs_low, hs_rise, in_load, out_load, in_take, out_done, intr_evt;

  assign hs_low   = ~hs_pin;
  assign hs_rise  = ~hs_prev & hs_pin;
  assign in_load  = dir_in & hs_low;
  assign out_load = ~dir_in & cpu_wr;
  assign in_take  = dir_in & cpu_rd;
  assign out_done = ~dir_in & hs_low;
  assign intr_evt = hs_rise & inte;
  assign intr     = pend_q & inte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_prev <= 1'b1;
      lat_q   <= '0;
      full_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      hs_prev <= hs_pin;
      if (clr) begin
        lat_q  <= '0;
        full_q <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        if (in_load)       lat_q <= pad_in;
        else if (out_load) lat_q <= wdata;
        if (in_load | out_load)      full_q <= 1'b1;
        else if (in_take | out_done) full_q <= 1'b0;
        if (out_load)      pend_q <= 1'b0;
        else if (intr_evt) pend_q <= 1'b1;
        else if (in_take)  pend_q <= 1'b0;
      end
    end
  end

  assert_write_fills_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_load && !clr) |=> (full_q && lat_q == $past(wdata)));

  assert_ack_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && !cpu_wr && !clr) |=> !full_q);

  assert_rise_pends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_evt && !out_load && !clr) |=> pend_q);

  assert_strobe_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_load && !clr) |=> (full_q && lat_q == $past(pad_in)));

  assert_read_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_take && !hs_low && !clr) |=> !full_q);

  assert_clear_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!full_q && !pend_q && lat_q == '0));
endmodule

// File: rtl/spp_pc_map.sv
module spp_pc_map
  import spp_pkg::*;
(
  input  spp_cfg_t           cfg,
  input  logic               full_a,
  input  logic               full_b,
  input  logic               intr_a,
  input  logic               intr_b,
  input  logic [SPARE_N-1:0] spare,
  input  logic [PC_W-1:0]    pc_in,
  output logic [PC_W-1:0]    pc_out,
  output logic [PC_W-1:0]    pc_oe,
  output logic               hs_a,
  output logic               hs_b,
  output logic [PC_W-1:0]    pc_view
);
  logic [SPARE_N-1:0] spare_drv;

  assign pc_oe     = pc_dir_mask(cfg);
  assign spare_drv = cfg.spare_in ? '0 : spare;
  assign hs_a      = cfg.a_in ? pc_in[4] : pc_in[6];
  assign hs_b      = pc_in[2];
  assign pc_view   = (pc_out & pc_oe) | (pc_in & ~pc_oe);

  always_comb begin
    pc_out    = '0;
    pc_out[3] = intr_a;
    pc_out[0] = intr_b;
    pc_out[1] = cfg.b_in ? full_b : ~full_b;
    if (cfg.a_in) begin
      pc_out[5] = full_a;
      pc_out[6] = spare_drv[0];
      pc_out[7] = spare_drv[1];
    end else begin
      pc_out[7] = ~full_a;
      pc_out[4] = spare_drv[0];
      pc_out[5] = spare_drv[1];
    end
  end

  always_comb begin
    assert_no_drive_on_input_R4: assert ((pc_out & ~pc_oe) == '0);
  end
endmodule

// File: rtl/strobed_port_pair.sv
module strobed_port_pair
  import spp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  input  logic [BUS_W-1:0] pa_in,
  output logic [BUS_W-1:0] pa_out,
  output logic             pa_oe,
  input  logic [BUS_W-1:0] pb_in,
  output logic [BUS_W-1:0] pb_out,
  output logic             pb_oe,
  input  logic [PC_W-1:0]  pc_in,
  output logic [PC_W-1:0]  pc_out,
  output logic [PC_W-1:0]  pc_oe
);
  spp_cfg_t           cfg;
  logic               mode_clr, inte_a, inte_b, ctl_wr, hs_a, hs_b;
  logic [SPARE_N-1:0] spare;
  logic [PC_W-1:0]    pc_view;

  logic [PORT_N-1:0] ch_dir, ch_inte, ch_wr, ch_rd, ch_hs, ch_full, ch_intr;
  logic [BUS_W-1:0]  ch_pad [PORT_N];
  logic [BUS_W-1:0]  ch_lat [PORT_N];

  assign ctl_wr = wr_en & (addr == ADDR_CTL);

  spp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wdata(wdata),
    .cfg(cfg), .mode_clr(mode_clr), .inte_a(inte_a), .inte_b(inte_b), .spare(spare)
  );

  assign ch_dir  = {cfg.b_in, cfg.a_in};
  assign ch_inte = {inte_b, inte_a};
  assign ch_hs   = {hs_b, hs_a};
  assign ch_pad[0] = pa_in;
  assign ch_pad[1] = pb_in;

  for (genvar i = 0; i < PORT_N; i++) begin : g_chan
    assign ch_wr[i] = wr_en & (addr == 2'(i));
    assign ch_rd[i] = rd_en & (addr == 2'(i));
    spp_chan #(.W(BUS_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .clr(mode_clr), .dir_in(ch_dir[i]), .inte(ch_inte[i]),
      .cpu_wr(ch_wr[i]), .cpu_rd(ch_rd[i]), .wdata(wdata), .pad_in(ch_pad[i]),
      .hs_pin(ch_hs[i]), .lat_q(ch_lat[i]), .full_q(ch_full[i]), .intr(ch_intr[i])
    );
  end

  spp_pc_map u_map (
    .cfg(cfg), .full_a(ch_full[0]), .full_b(ch_full[1]),
    .intr_a(ch_intr[0]), .intr_b(ch_intr[1]), .spare(spare), .pc_in(pc_in),
    .pc_out(pc_out), .pc_oe(pc_oe), .hs_a(hs_a), .hs_b(hs_b), .pc_view(pc_view)
  );

  assign pa_oe  = ~cfg.a_in;
  assign pb_oe  = ~cfg.b_in;
  assign pa_out = cfg.a_in ? '0 : ch_lat[0];
  assign pb_out = cfg.b_in ? '0 : ch_lat[1];

  always_comb begin
    case (addr)
      2'd0:     rdata = ch_lat[0];
      2'd1:     rdata = ch_lat[1];
      ADDR_PC:  rdata = pc_view;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: tb/tb_strobed_port_pair.sv
module tb_strobed_port_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00, rdata;
  logic [7:0] pa_in = 8'h00, pa_out, pb_in = 8'h00, pb_out;
  logic       pa_oe, pb_oe;
  logic [7:0] pc_in = 8'hFF, pc_out, pc_oe;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  strobed_port_pair dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in), .pc_out(pc_out),
    .pc_oe(pc_oe)
  );

  always #2 clk = ~clk;

  // Reference state: index 0 = port A, 1 = port B
  logic       m_dir [2];
  logic       m_full [2], m_pend [2], m_prev [2], m_inte [2];
  logic [7:0] m_lat [2];
  logic       m_spin;
  logic       m_sp [2];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_dir[i] = 1'b1; m_full[i] = 1'b0; m_pend[i] = 1'b0;
      m_prev[i] = 1'b1; m_inte[i] = 1'b0; m_lat[i] = 8'h00; m_sp[i] = 1'b0;
    end
    m_spin = 1'b1;
  endtask

  function automatic logic [7:0] exp_oe();
    logic [7:0] o = 8'h00;
    o[0] = 1'b1; o[1] = 1'b1; o[3] = 1'b1;
    if (m_dir[0]) begin o[5] = 1'b1; o[6] = !m_spin; o[7] = !m_spin; end
    else begin o[7] = 1'b1; o[4] = !m_spin; o[5] = !m_spin; end
    return o;
  endfunction

  function automatic logic [7:0] exp_out();
    logic [7:0] o = 8'h00;
    o[3] = m_pend[0] & m_inte[0];
    o[0] = m_pend[1] & m_inte[1];
    o[1] = m_dir[1] ? m_full[1] : !m_full[1];
    if (m_dir[0]) begin
      o[5] = m_full[0];
      if (!m_spin) begin o[6] = m_sp[0]; o[7] = m_sp[1]; end
    end else begin
      o[7] = !m_full[0];
      if (!m_spin) begin o[4] = m_sp[0]; o[5] = m_sp[1]; end
    end
    return o;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] a, input logic [7:0] pc);
    case (a)
      2'd0: return m_lat[0];
      2'd1: return m_lat[1];
      2'd2: return (exp_out() & exp_oe()) | (pc & ~exp_oe());
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [63:0] exp_pins();
    return {30'd0, !m_dir[0], (m_dir[0] ? 8'h00 : m_lat[0]),
            !m_dir[1], (m_dir[1] ? 8'h00 : m_lat[1]), exp_oe(), exp_out()};
  endfunction

  function automatic logic [63:0] act_pins();
    return {30'd0, pa_oe, pa_out, pb_oe, pb_out, pc_oe, pc_out};
  endfunction

  task automatic model_step(input logic wr, input logic rd, input logic [1:0] a,
                            input logic [7:0] wd, input logic [7:0] pa,
                            input logic [7:0] pb, input logic [7:0] pc);
    logic mode_ok, bsr;
    logic [2:0] sel;
    mode_ok = wr && a == 2'd3 && wd[7] && wd[6:5] == 2'b01 && wd[2];
    bsr = wr && a == 2'd3 && !wd[7];
    for (int i = 0; i < 2; i++) begin
      logic hs, rise, wi, ri;
      logic [7:0] pad;
      hs = (i == 0) ? (m_dir[0] ? pc[4] : pc[6]) : pc[2];
      rise = !m_prev[i] && hs;
      wi = wr && a == 2'(i);
      ri = rd && a == 2'(i);
      pad = (i == 0) ? pa : pb;
      m_prev[i] = hs;
      if (mode_ok) begin
        m_lat[i] = 8'h00; m_full[i] = 1'b0; m_pend[i] = 1'b0;
      end else if (m_dir[i]) begin
        if (!hs) begin m_lat[i] = pad; m_full[i] = 1'b1; end
        else if (ri) m_full[i] = 1'b0;
        if (rise && m_inte[i]) m_pend[i] = 1'b1;
        else if (ri) m_pend[i] = 1'b0;
      end else begin
        if (wi) begin m_lat[i] = wd; m_full[i] = 1'b1; m_pend[i] = 1'b0; end
        else begin
          if (!hs) m_full[i] = 1'b0;
          if (rise && m_inte[i]) m_pend[i] = 1'b1;
        end
      end
    end
    sel = wd[3:1];
    if (mode_ok) begin
      m_dir[0] = wd[4]; m_dir[1] = wd[1]; m_spin = wd[3];
      m_inte[0] = 1'b0; m_inte[1] = 1'b0; m_sp[0] = 1'b0; m_sp[1] = 1'b0;
    end else if (bsr) begin
      if (sel == (m_dir[0] ? 3'd4 : 3'd6)) m_inte[0] = wd[0];
      if (sel == 3'd2) m_inte[1] = wd[0];
      if (m_dir[0] ? (sel == 3'd6 || sel == 3'd7) : (sel == 3'd4 || sel == 3'd5))
        m_sp[sel[0]] = wd[0];
    end
  endtask

  // One clock cycle: drive, check read data, advance reference, check pins after edge
  task automatic cyc(input logic wr, input logic rd, input logic [1:0] a,
                     input logic [7:0] wd, input logic [7:0] pa,
                     input logic [7:0] pb, input logic [7:0] pc);
    wr_en = wr; rd_en = rd; addr = a; wdata = wd; pa_in = pa; pb_in = pb; pc_in = pc;
    #1;
    if (rd) chk("R11 rdata", 64'(rdata), 64'(exp_rd(a, pc)));
    model_step(wr, rd, a, wd, pa, pb, pc);
    @(posedge clk);
    #1;
    chk("R4/R5 pins", act_pins(), exp_pins());
  endtask

  task automatic idle(input logic [7:0] pc);
    cyc(1'b0, 1'b0, 2'd0, 8'h00, 8'h00, 8'h00, pc);
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    wr_en = 1'b0; rd_en = 1'b0; addr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] pcv;
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 oe", 64'({pa_oe, pb_oe}), 64'(0));
    chk("R1 pc_oe", 64'(pc_oe), 64'(8'h2B));
    chk("R1 pc_out", 64'(pc_out), 64'(8'h00));
    peek(2'd0, d);
    chk("R1 latch A", 64'(d), 64'(0));
    // R2 malformed mode word ignored
    cyc(1, 0, 2'd3, 8'h80, 8'h00, 8'h00, 8'hFF);
    chk("R2 bad word", 64'(pc_oe), 64'(8'h2B));
    // R2 both outputs, spare outputs
    cyc(1, 0, 2'd3, 8'hA4, 8'h00, 8'h00, 8'hFF);
    chk("R2 oe", 64'({pa_oe, pb_oe, pc_oe}), 64'({2'b11, 8'hBB}));
    chk("R5 obf idle", 64'(pc_out), 64'(8'h82));
    // R6 write fills A
    cyc(1, 0, 2'd0, 8'h5A, 8'h00, 8'h00, 8'hFF);
    chk("R6 write A", 64'({pa_out, pc_out}), 64'({8'h5A, 8'h02}));
    cyc(1, 0, 2'd3, 8'h0D, 8'h00, 8'h00, 8'hFF);
    cyc(1, 0, 2'd3, 8'h05, 8'h00, 8'h00, 8'hFF);
    cyc(0, 0, 2'd0, 8'h00, 8'h00, 8'h00, 8'hBF);
    chk("R6 ack empties", 64'(pc_out), 64'(8'h82));
    idle(8'hFF);
    chk("R7 ack rise intr", 64'(pc_out), 64'(8'h8A));
    cyc(1, 0, 2'd0, 8'h11, 8'h00, 8'h00, 8'hFF);
    chk("R7 write clears intr", 64'(pc_out), 64'(8'h02));
    // R10 spare set, non-selectable bit ignored
    cyc(1, 0, 2'd3, 8'h09, 8'h00, 8'h00, 8'hFF);
    chk("R10 spare bit", 64'(pc_out), 64'(8'h12));
    cyc(1, 0, 2'd3, 8'h01, 8'h00, 8'h00, 8'hFF);
    chk("R10 ignored bit", 64'(pc_out), 64'(8'h12));
    // R6 write wins over low acknowledge
    cyc(1, 0, 2'd1, 8'hC3, 8'h00, 8'h00, 8'hFB);
    chk("R6 write beats ack", 64'({pb_out, pc_out}), 64'({8'hC3, 8'h10}));
    idle(8'hFF);
    chk("R7 B intr", 64'(pc_out), 64'(8'h11));
    // R3 new configuration clears all
    cyc(1, 0, 2'd3, 8'hB6, 8'h00, 8'h00, 8'hFF);
    chk("R3 oe", 64'({pa_oe, pb_oe, pc_oe}), 64'({2'b00, 8'hEB}));
    chk("R3 pc_out", 64'(pc_out), 64'(8'h00));
    peek(2'd1, d);
    chk("R3 latch B", 64'(d), 64'(0));
    // R8/R9 input handshake on A
    cyc(1, 0, 2'd3, 8'h09, 8'h00, 8'h00, 8'hFF);
    cyc(1, 0, 2'd3, 8'h05, 8'h00, 8'h00, 8'hFF);
    cyc(0, 0, 2'd0, 8'h00, 8'h3C, 8'h00, 8'hEF);
    chk("R8 strobe fills", 64'(pc_out), 64'(8'h20));
    cyc(0, 0, 2'd0, 8'h00, 8'h77, 8'h00, 8'hFF);
    chk("R9 strobe rise intr", 64'(pc_out), 64'(8'h28));
    peek(2'd0, d);
    chk("R11 latch A", 64'(d), 64'(8'h3C));
    cyc(1, 0, 2'd0, 8'hEE, 8'h00, 8'h00, 8'hFF);
    chk("R8 write to input ignored", 64'(pc_out), 64'(8'h28));
    cyc(0, 1, 2'd0, 8'h00, 8'h00, 8'h00, 8'hFF);
    chk("R9 read clears", 64'(pc_out), 64'(8'h00));
    // R8 strobe beats read on B
    cyc(0, 1, 2'd1, 8'h00, 8'h00, 8'h99, 8'hFB);
    chk("R8 strobe beats read", 64'(pc_out), 64'(8'h02));
    // R10 disabling enable blocks interrupt
    cyc(1, 0, 2'd3, 8'h04, 8'h00, 8'h99, 8'hFB);
    idle(8'hFF);
    chk("R10 disabled intr", 64'(pc_out), 64'(8'h02));
    peek(2'd1, d);
    chk("R8 latch B", 64'(d), 64'(8'h99));
    peek(2'd3, d);
    chk("R11 ctl reads zero", 64'(d), 64'(0));

    // Constrained random phase
    pcv = 8'hFF;
    for (int k = 0; k < 3000; k++) begin
      int op;
      logic [7:0] w;
      op = int'($urandom % 8);
      pcv = pcv ^ (8'($urandom) & 8'($urandom));
      w = 8'($urandom);
      case (op)
        0, 1: cyc(1, 0, 2'(op), w, 8'($urandom), 8'($urandom), pcv);
        2, 3: cyc(0, 1, 2'(op - 2), w, 8'($urandom), 8'($urandom), pcv);
        4:    cyc(0, 1, 2'(2 + ($urandom % 2)), w, 8'($urandom), 8'($urandom), pcv);
        5: begin
          int s;
          s = int'($urandom % 10);
          if (s == 0) w = {3'b101, w[4:3], 1'b1, w[1:0]};
          else if (s == 1) w = {1'b1, ~w[6], w[5:0]};
          else w = {4'b0000, w[3:0]};
          cyc(1, 0, 2'd3, w, 8'($urandom), 8'($urandom), pcv);
        end
        default: cyc(0, 0, 2'd0, w, 8'($urandom), 8'($urandom), pcv);
      endcase
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule